// File: doc/BRIEF.md
# Serial Program-Verify Command Engine

This block is the target-side protocol engine for a two-wire serial program-and-verify port. A host drives a slow serial clock and a shared data line. The block samples both with a fast system clock, shifts in a short command, and decodes it. For commands that carry a data word, it then moves a sixteen-clock data frame in either direction. The frame is a zero start bit, the data word least significant bit first, and a zero stop bit.

The block has no storage array and no address counter. Each decoded action leaves the block as a one-cycle strobe. The surrounding logic (an address counter and a programming controller) reacts to these strobes. A loaded word is presented on a parallel output. A word to be read back is taken from a parallel input when the read command completes. A busy input from the programming controller can veto new programming or erase starts. A mode-enable input aborts any transfer in progress and frees the data line.

Top module: `spv_cmd_if`

## Requirements
- R1: After reset, the data-line enable and data output are low, no strobe fires, and the load word is zero.
- R2: A command is six serial clocks. Each bit is sampled when the serial clock falls, least significant bit first. Code 0b000110 gives one increment strobe, and the next command follows at once with no data frame.
- R3: Only the low four command bits are decoded. The top two bits are ignored, so 0b110110 also gives an increment strobe.
- R4: Code 0b000010 (load) is followed by a 16-clock frame. The data bit for bit k is captured on falling edge k+2 of the frame. After falling edge 16 and not before, a load strobe fires and the load word output shows the 14 captured bits.
- R5: Code 0b000000 (configuration select) also takes a 16-clock frame. The frame content is discarded and the load word output keeps its old value. A configuration strobe fires after falling edge 16.
- R6: For code 0b000100 (read), the read word input is captured when the command completes. The data line is not driven after rising edge 1 of the frame. From rising edge 2 to rising edge 15 it drives bit (edge - 2), and at rising edge 16 it drives the zero stop bit. The line is released after falling edge 16.
- R7: Code 0b001000 gives a program-begin strobe, 0b001001 an erase strobe, and 0b001110 a program-end strobe. None of these takes a frame.
- R8: While busy is high, program-begin and erase codes give no strobe. Program-end still gives its strobe.
- R9: Codes other than the seven above (low four bits 0001, 0011, 0101, 0111, 1010–1101, 1111) give no strobe and expect no frame.
- R10: When mode-enable is low, the data-line enable goes low in the same cycle without waiting for a clock edge. Any partial command or frame is dropped. After mode-enable returns, decoding starts again at a fresh command.
- R11: Each strobe is high for exactly one system clock, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Program-verify mode enable; low aborts and releases the line |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat_i | input | 1 | Serial data from the host |
| ser_dat_o | output | 1 | Serial data toward the host during a read |
| ser_dat_oe | output | 1 | Drive enable for the serial data line |
| busy_i | input | 1 | Programming controller busy; vetoes begin and erase |
| rd_word_i | input | 14 | Word returned by a read frame |
| ld_word_o | output | 14 | Word captured by the last load frame |
| cfg_sel_o | output | 1 | Strobe: point the address counter at configuration space |
| ld_stb_o | output | 1 | Strobe: load word is valid |
| incr_o | output | 1 | Strobe: advance address |
| prog_begin_o | output | 1 | Strobe: start programming |
| erase_o | output | 1 | Strobe: start bulk erase |
| prog_end_o | output | 1 | Strobe: end programming |

## Verification
The bench builds the block with its defaults: a 6-bit command, a 14-bit word, a two-stage synchronizer and busy gating switched on. The serial half-period is ten system clocks, which is well above the synchronizer and edge-detect latency. This lets the bench watch the data line between individual serial edges of a read frame. It can also check that no load strobe fires before the final falling edge. Drops of mode-enable in mid-frame are checked between system edges, which shows that the line release is combinational.

// File: rtl/spv_pkg.sv
package spv_pkg;
   localparam int unsigned OPC_BITS = 4;

   localparam logic [OPC_BITS-1:0] OPC_CFG   = 4'h0;
   localparam logic [OPC_BITS-1:0] OPC_LOAD  = 4'h2;
   localparam logic [OPC_BITS-1:0] OPC_READ  = 4'h4;
   localparam logic [OPC_BITS-1:0] OPC_INCR  = 4'h6;
   localparam logic [OPC_BITS-1:0] OPC_BEGIN = 4'h8;
   localparam logic [OPC_BITS-1:0] OPC_ERASE = 4'h9;
   localparam logic [OPC_BITS-1:0] OPC_END   = 4'hE;

   typedef enum logic {ST_CMD, ST_FRAME} spv_state_e;
   typedef enum logic [1:0] {FK_CFG, FK_LOAD, FK_READ} spv_frame_e;

   typedef struct packed {
      logic       frame;
      spv_frame_e kind;
      logic       incr;
      logic       pbegin;
      logic       erase;
      logic       pend;
   } spv_dec_t;
endpackage

// File: rtl/spv_sync.sv
module spv_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spv_sync needs at least two stages");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spv_edge.sv
module spv_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sig,
   output logic rise,
   output logic fall
);
   logic prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev <= 1'b0;
      else if (!en) prev <= 1'b0;
      else          prev <= sig;
   end
   assign rise = en & sig & ~prev;
   assign fall = en & ~sig & prev;
endmodule

// File: rtl/spv_decode.sv
module spv_decode
   import spv_pkg::*;
#(
   parameter int unsigned CMD_BITS = 6
) (
   input  logic [CMD_BITS-1:0] cmd,
   output spv_dec_t            dec
);
   generate
      if (CMD_BITS < OPC_BITS) begin : g_bad
         $error("command must hold the opcode field");
      end
      if (CMD_BITS > OPC_BITS) begin : g_pad
         logic unused_hi;
         assign unused_hi = ^cmd[CMD_BITS-1:OPC_BITS];
      end
   endgenerate

   logic [OPC_BITS-1:0] opc;
   assign opc = cmd[OPC_BITS-1:0];

   always_comb begin
      dec = '0;
      dec.kind = FK_CFG;
      unique case (opc)
         OPC_CFG:   begin dec.frame = 1'b1; dec.kind = FK_CFG;  end
         OPC_LOAD:  begin dec.frame = 1'b1; dec.kind = FK_LOAD; end
         OPC_READ:  begin dec.frame = 1'b1; dec.kind = FK_READ; end
         OPC_INCR:  dec.incr   = 1'b1;
         OPC_BEGIN: dec.pbegin = 1'b1;
         OPC_ERASE: dec.erase  = 1'b1;
         OPC_END:   dec.pend   = 1'b1;
         default:   dec = dec;
      endcase
   end
endmodule

// File: rtl/spv_cmd_if.sv
module spv_cmd_if
   import spv_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 14,
   parameter int unsigned CMD_BITS    = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          GATE_BUSY   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_en,
   input  logic                 ser_clk,
   input  logic                 ser_dat_i,
   output logic                 ser_dat_o,
   output logic                 ser_dat_oe,
   input  logic                 busy_i,
   input  logic [DATA_BITS-1:0] rd_word_i,
   output logic [DATA_BITS-1:0] ld_word_o,
   output logic                 cfg_sel_o,
   output logic                 ld_stb_o,
   output logic                 incr_o,
   output logic                 prog_begin_o,
   output logic                 erase_o,
   output logic                 prog_end_o
);
   localparam int unsigned FRAME_BITS = DATA_BITS + 2;
   localparam int unsigned CW = $clog2(FRAME_BITS + 1);

   generate
      if (DATA_BITS < 1) begin : g_bad_data
         $error("data word must have at least one bit");
      end
      if (CMD_BITS >= FRAME_BITS) begin : g_bad_cmd
         $error("command longer than frame counter range");
      end
   endgenerate

   // synchronise and find serial clock edges
   logic [1:0] pins_s;
   logic       sclk_s, sdat_s, s_rise, s_fall;

   spv_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ser_dat_i, ser_clk}), .q(pins_s)
   );
   assign sclk_s = pins_s[0];
   assign sdat_s = pins_s[1];

   spv_edge u_edge (
      .clk(clk), .rst_n(rst_n), .en(mode_en), .sig(sclk_s),
      .rise(s_rise), .fall(s_fall)
   );

   // state
   spv_state_e           st;
   spv_frame_e           kind;
   logic [CW-1:0]        fcnt, rcnt;
   logic [CMD_BITS-1:0]  cmd_sh, cmd_nxt;
   logic [DATA_BITS-1:0] ld_sh, rd_sh, ld_q;
   logic                 dout_q, oe_q;
   logic                 stb_cfg, stb_ld, stb_inc, stb_beg, stb_era, stb_end;
   spv_dec_t             dec;
   logic                 allow_start;

   assign cmd_nxt = {sdat_s, cmd_sh[CMD_BITS-1:1]};

   spv_decode #(.CMD_BITS(CMD_BITS)) u_dec (.cmd(cmd_nxt), .dec(dec));

   generate
      if (GATE_BUSY) begin : g_gate
         assign allow_start = ~busy_i;
      end else begin : g_nogate
         logic unused_busy;
         assign unused_busy = busy_i;
         assign allow_start = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_CMD; kind <= FK_CFG;
         fcnt <= '0; rcnt <= '0;
         cmd_sh <= '0; ld_sh <= '0; rd_sh <= '0; ld_q <= '0;
         dout_q <= 1'b0; oe_q <= 1'b0;
         {stb_cfg, stb_ld, stb_inc, stb_beg, stb_era, stb_end} <= '0;
      end else begin
         {stb_cfg, stb_ld, stb_inc, stb_beg, stb_era, stb_end} <= '0;
         if (!mode_en) begin
            st <= ST_CMD; fcnt <= '0; rcnt <= '0;
            dout_q <= 1'b0; oe_q <= 1'b0;
         end else if (st == ST_CMD) begin
            if (s_fall) begin
               cmd_sh <= cmd_nxt;
               if (fcnt == CW'(CMD_BITS - 1)) begin
                  fcnt <= '0;
                  rcnt <= '0;
                  if (dec.frame) begin
                     st   <= ST_FRAME;
                     kind <= dec.kind;
                     if (dec.kind == FK_READ) rd_sh <= rd_word_i;
                  end
                  stb_inc <= dec.incr;
                  stb_beg <= dec.pbegin & allow_start;
                  stb_era <= dec.erase & allow_start;
                  stb_end <= dec.pend;
               end else begin
                  fcnt <= fcnt + 1'b1;
               end
            end
         end else begin
            if (s_rise) begin
               rcnt <= rcnt + 1'b1;
               if (kind == FK_READ && rcnt != '0) begin
                  oe_q <= 1'b1;
                  if (rcnt <= CW'(DATA_BITS)) begin
                     dout_q <= rd_sh[0];
                     rd_sh  <= rd_sh >> 1;
                  end else begin
                     dout_q <= 1'b0;
                  end
               end
            end
            if (s_fall) begin
               if (fcnt != '0 && fcnt <= CW'(DATA_BITS))
                  ld_sh <= {sdat_s, ld_sh[DATA_BITS-1:1]};
               if (fcnt == CW'(FRAME_BITS - 1)) begin
                  st <= ST_CMD; fcnt <= '0; oe_q <= 1'b0; dout_q <= 1'b0;
                  if (kind == FK_LOAD) begin
                     ld_q   <= ld_sh;
                     stb_ld <= 1'b1;
                  end
                  stb_cfg <= (kind == FK_CFG);
               end else begin
                  fcnt <= fcnt + 1'b1;
               end
            end
         end
      end
   end

   assign ser_dat_oe   = oe_q & mode_en;
   assign ser_dat_o    = dout_q & mode_en;
   assign ld_word_o    = ld_q;
   assign cfg_sel_o    = stb_cfg;
   assign ld_stb_o     = stb_ld;
   assign incr_o       = stb_inc;
   assign prog_begin_o = stb_beg;
   assign erase_o      = stb_era;
   assign prog_end_o   = stb_end;

   // R11: strobes are exclusive and last one cycle
   a_r11_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_sel_o, ld_stb_o, incr_o, prog_begin_o, erase_o, prog_end_o}));
   a_r11_incr_single: assert property (@(posedge clk) disable iff (!rst_n)
      incr_o |=> !incr_o);
   a_r11_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb_o |=> !ld_stb_o);

   // R6: the line is driven only inside a read frame
   a_r6_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      ser_dat_oe |-> (st == ST_FRAME && kind == FK_READ));

   // R4: the load word changes only together with a load strobe
   a_r4_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_stb_o |-> $stable(ld_word_o));

   // R10: mode drop leaves the engine idle with the line released
   a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> (st == ST_CMD && !oe_q));

   generate
      if (GATE_BUSY) begin : g_busy_chk
         // R8: no start strobe follows a busy cycle
         a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_begin_o || erase_o) |-> !$past(busy_i));
      end
   endgenerate
endmodule

// File: tb/spv_cmd_if_bench.sv
module spv_cmd_if_bench;
   localparam int HP = 10;
   localparam int SW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_en = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat_i = 1'b0;
   logic        ser_dat_o, ser_dat_oe;
   logic        busy_i = 1'b0;
   logic [13:0] rd_word_i = '0;
   logic [13:0] ld_word_o;
   logic        cfg_sel_o, ld_stb_o, incr_o, prog_begin_o, erase_o, prog_end_o;

   int checks = 0, failures = 0;
   int n_cfg = 0, n_ld = 0, n_inc = 0, n_beg = 0, n_era = 0, n_end = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spv_cmd_if u_spv_cmd_if (
      .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .ser_clk(ser_clk),
      .ser_dat_i(ser_dat_i), .ser_dat_o(ser_dat_o), .ser_dat_oe(ser_dat_oe),
      .busy_i(busy_i), .rd_word_i(rd_word_i), .ld_word_o(ld_word_o),
      .cfg_sel_o(cfg_sel_o), .ld_stb_o(ld_stb_o), .incr_o(incr_o),
      .prog_begin_o(prog_begin_o), .erase_o(erase_o), .prog_end_o(prog_end_o)
   );

   always @(posedge clk) begin
      n_cfg <= n_cfg + int'(cfg_sel_o);
      n_ld  <= n_ld  + int'(ld_stb_o);
      n_inc <= n_inc + int'(incr_o);
      n_beg <= n_beg + int'(prog_begin_o);
      n_era <= n_era + int'(erase_o);
      n_end <= n_end + int'(prog_end_o);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr;
      wait_cyc(2);
      n_cfg = 0; n_ld = 0; n_inc = 0; n_beg = 0; n_era = 0; n_end = 0;
   endtask

   task automatic ser_cycle(input logic b);
      ser_dat_i = b;
      wait_cyc(HP);
      ser_clk = 1'b1;
      wait_cyc(HP);
      ser_clk = 1'b0;
      wait_cyc(HP);
   endtask

   task automatic send_cmd(input logic [5:0] c);
      for (int i = 0; i < 6; i++) ser_cycle(c[i]);
   endtask

   task automatic send_frame(input logic [13:0] w);
      for (int j = 0; j < 16; j++)
         ser_cycle((j == 0 || j == 15) ? 1'b0 : w[j-1]);
   endtask

   function automatic int total();
      return n_cfg + n_ld + n_inc + n_beg + n_era + n_end;
   endfunction

   task automatic t_reset;
      chk(ser_dat_oe == 1'b0, "R1 oe", int'(ser_dat_oe), 0);
      chk(ser_dat_o == 1'b0, "R1 dout", int'(ser_dat_o), 0);
      chk(ld_word_o == 14'h0, "R1 word", int'(ld_word_o), 0);
      chk(total() == 0, "R1 strobes", total(), 0);
   endtask

   task automatic t_incr;
      clr();
      send_cmd(6'b000110);
      chk(n_inc == 1 && total() == 1, "R2 incr one pulse (R11)", n_inc, 1);
      send_cmd(6'b110110);
      chk(n_inc == 2 && total() == 2, "R3 upper bits ignored", n_inc, 2);
   endtask

   task automatic t_load(input logic [13:0] w);
      clr();
      send_cmd(6'b000010);
      for (int j = 0; j < 15; j++) ser_cycle((j == 0) ? 1'b0 : w[j-1]);
      chk(n_ld == 0, "R4 no strobe before last fall", n_ld, 0);
      ser_cycle(1'b0);
      chk(n_ld == 1 && total() == 1, "R4 load strobe", n_ld, 1);
      chk(ld_word_o == w, "R4 load word", int'(ld_word_o), int'(w));
   endtask

   task automatic t_cfg;
      logic [13:0] prev;
      prev = ld_word_o;
      clr();
      send_cmd(6'b000000);
      send_frame(14'h1555);
      chk(n_cfg == 1 && total() == 1, "R5 cfg strobe", n_cfg, 1);
      chk(ld_word_o == prev, "R5 frame discarded", int'(ld_word_o), int'(prev));
   endtask

   task automatic t_read(input logic [13:0] w);
      rd_word_i = w;
      clr();
      send_cmd(6'b000100);
      rd_word_i = ~w;
      for (int k = 1; k <= 16; k++) begin
         wait_cyc(HP);
         ser_clk = 1'b1;
         wait_cyc(SW);
         if (k == 1) begin
            chk(ser_dat_oe == 1'b0, "R6 undriven at rise 1", int'(ser_dat_oe), 0);
         end else begin
            chk(ser_dat_oe == 1'b1, "R6 driven", int'(ser_dat_oe), 1);
            if (k <= 15)
               chk(ser_dat_o == w[k-2], "R6 data bit", int'(ser_dat_o), int'(w[k-2]));
            else
               chk(ser_dat_o == 1'b0, "R6 stop bit", int'(ser_dat_o), 0);
         end
         wait_cyc(HP - SW);
         ser_clk = 1'b0;
         wait_cyc(HP);
      end
      chk(ser_dat_oe == 1'b0, "R6 released after frame", int'(ser_dat_oe), 0);
      chk(total() == 0, "R6 no strobe on read", total(), 0);
   endtask

   task automatic t_ctrl;
      clr();
      send_cmd(6'b001000);
      send_cmd(6'b001001);
      send_cmd(6'b001110);
      chk(n_beg == 1, "R7 begin", n_beg, 1);
      chk(n_era == 1, "R7 erase", n_era, 1);
      chk(n_end == 1 && total() == 3, "R7 end", n_end, 1);
   endtask

   task automatic t_busy;
      busy_i = 1'b1;
      clr();
      send_cmd(6'b001000);
      send_cmd(6'b001001);
      send_cmd(6'b001110);
      chk(n_beg == 0 && n_era == 0, "R8 starts vetoed", n_beg + n_era, 0);
      chk(n_end == 1, "R8 end passes", n_end, 1);
      busy_i = 1'b0;
   endtask

   task automatic t_unknown;
      clr();
      send_cmd(6'b000001);
      send_cmd(6'b001111);
      send_cmd(6'b000011);
      chk(total() == 0, "R9 unknown ignored", total(), 0);
      send_cmd(6'b000110);
      chk(n_inc == 1 && total() == 1, "R9 no frame after unknown", total(), 1);
   endtask

   task automatic t_abort;
      rd_word_i = 14'h3FFF;
      clr();
      send_cmd(6'b000100);
      for (int k = 1; k <= 3; k++) begin
         wait_cyc(HP);
         ser_clk = 1'b1;
         wait_cyc(HP);
         if (k < 3) begin
            ser_clk = 1'b0;
            wait_cyc(HP);
         end
      end
      chk(ser_dat_oe == 1'b1, "R10 driving before abort", int'(ser_dat_oe), 1);
      #1 mode_en = 1'b0;
      #1 chk(ser_dat_oe == 1'b0, "R10 immediate release", int'(ser_dat_oe), 0);
      wait_cyc(HP);
      ser_clk = 1'b0;
      wait_cyc(HP);
      mode_en = 1'b1;
      wait_cyc(HP);
      send_cmd(6'b000110);
      chk(n_inc == 1 && total() == 1, "R10 fresh command after abort", total(), 1);
   endtask

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);
      t_reset();
      mode_en = 1'b1;
      wait_cyc(HP);
      t_incr();
      t_load(14'h2A5C);
      t_load(14'h2001);
      t_cfg();
      t_read(14'h2C93);
      t_read(14'h3FFE);
      t_ctrl();
      t_busy();
      t_unknown();
      t_abort();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule